// File: doc/BRIEF.md
# Successive Approximation Converter Sequencer

This block is the digital control half of an 8-bit successive-approximation analog-to-digital converter with eight inputs. A start request latches a channel number and the clock settings, then the block walks a fixed schedule: it holds the sample switch closed while the chosen input settles, then resolves the code one bit at a time from the most significant bit down. On each step it drives a trial code to an external DAC and reads back one comparator bit. When the schedule ends it loads the result register, raises a one-cycle completion pulse and sets a sticky interrupt flag.

All timing is counted in conversion-clock periods. The conversion clock comes from the system clock through two settings. A 2-bit prescaler code picks a base divide of 2, 4 or 16. A separate halving bit then either passes that base clock through or divides it by two again. A conversion always lasts 160 conversion-clock periods. The first 12 of them are sampling, each of the 8 bit decisions takes 17, and the last 12 are a settle tail before the result loads.

The result port has no back-pressure. `done_pulse` marks the single cycle in which a new `result` value first appears, and that value stays until the next conversion completes. Control and status pins are plain levels or pulses.

Top module: `sar_adc_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done_pulse`, `irq_flag` and `sample_hold` are 0, and `result` and `trial_code` are 0.
- R2: A `start` seen at a clock edge while idle raises `busy` after that edge and latches `chan_sel` onto `mux_sel`. `mux_sel` keeps that value until the next accepted start, whatever `chan_sel` does.
- R3: `sample_hold` is 1 for exactly 12·N system cycles after the start edge, where N is the divide from R7. `trial_code` is 0 throughout that window.
- R4: In the cycle in which `sample_hold` falls, `trial_code` is 0x80. Every 17·N cycles after that, the bit under test is kept if `cmp_above` is 1 (input at or above the trial level) or cleared if it is 0, and the next lower bit is set. The MSB is decided first.
- R5: With an ideal comparator, `result` equals the largest code that is not above the selected input level.
- R6: `done_pulse` is 1 exactly 160·N system cycles after the start edge, and `result` holds the new code in that cycle.
- R7: N = B·M. B is 2, 4 or 16 for prescaler codes 00, 01 and 11. Code 10 acts like 11. M is 1 when `clk_half` is 0 and 2 when it is 1. Both settings are sampled only at an accepted start.
- R8: A `start` that arrives while `busy` is 1 is ignored: the channel, the timing and the result of the running conversion are unchanged.
- R9: `done_pulse` lasts one cycle. `irq_flag` goes to 1 with it and stays 1 until `irq_clr` is seen. A completion in the same cycle as `irq_clr` leaves the flag at 1.
- R10: `busy` stays 1 without a gap from the cycle after the start edge until the cycle in which `done_pulse` is 1, and is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request, sampled each edge |
| chan_sel | input | 3 | Input channel to convert |
| psc_code | input | 2 | Prescaler code, base divide 2/4/16 |
| clk_half | input | 1 | 1 halves the prescaled clock again |
| irq_clr | input | 1 | Clears the interrupt flag |
| cmp_above | input | 1 | Comparator: 1 when input is at or above trial level |
| mux_sel | output | 3 | Analog multiplexer select |
| sample_hold | output | 1 | 1 while the sample switch is closed |
| trial_code | output | 8 | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| result | output | 8 | Last completed conversion code |
| done_pulse | output | 1 | One-cycle completion strobe |
| irq_flag | output | 1 | Sticky completion interrupt |

## Verification
Every result is due a fixed number of system cycles after the edge that accepts `start`. `busy` and `mux_sel` change one edge later. `sample_hold` falls and `trial_code` becomes 0x80 after 12·N edges. The MSB decision shows after 29·N edges. `done_pulse`, `result` and `irq_flag` arrive after 160·N edges. The bench drives inputs on falling edges and counts falling edges from the accepting edge. It compares each count against the product of the budget and the divide it computes from the prescaler code and the halving bit. Input levels are placed on the selected channel, and different levels on all other channels, so a wrong multiplexer select shows up as a wrong code.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  typedef enum logic [1:0] {
    PSC_DIV2  = 2'b00,
    PSC_DIV4  = 2'b01,
    PSC_RSVD  = 2'b10,
    PSC_DIV16 = 2'b11
  } psc_code_e;

  // System cycles per conversion-clock period for a prescaler code and halving bit.
  function automatic int unsigned conv_divisor(input logic [1:0] psc, input logic half);
    int unsigned base;
    case (psc_code_e'(psc))
      PSC_DIV2: base = 2;
      PSC_DIV4: base = 4;
      default:  base = 16;  // reserved code shares the slowest base
    endcase
    return half ? 2 * base : base;
  endfunction

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div
  import sar_adc_pkg::*;
#(
  parameter int MAX_DIV = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       run,
  input  logic [1:0] psc,
  input  logic       half,
  output logic       tick
);
  localparam int DW = $clog2(MAX_DIV);

  logic [DW-1:0] cnt;
  logic [DW-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lim <= '0;
    end else if (load) begin
      cnt <= '0;
      lim <= DW'(conv_divisor(psc, half) - 1);
    end else if (run) begin
      cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == lim);

endmodule

// File: rtl/sar_phase_ctr.sv
module sar_phase_ctr #(
  parameter int RES   = 8,
  parameter int SAMP  = 12,
  parameter int BITP  = 17,
  parameter int TOTAL = 160
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           run,
  input  logic           tick,
  output logic           sampling,
  output logic           samp_end,
  output logic [RES-1:0] dec,
  output logic           conv_end
);
  localparam int TCW = $clog2(TOTAL + 1);

  logic [TCW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tcnt <= '0;
    else if (load)  tcnt <= '0;
    else if (tick)  tcnt <= tcnt + 1'b1;
  end

  assign sampling = run && (tcnt < TCW'(SAMP));
  assign samp_end = tick && (tcnt == TCW'(SAMP - 1));
  assign conv_end = tick && (tcnt == TCW'(TOTAL - 1));

  // Step k decides bit RES-1-k at the last period of its slot.
  for (genvar k = 0; k < RES; k++) begin : g_step
    assign dec[RES-1-k] = tick && (tcnt == TCW'(SAMP + (k + 1) * BITP - 1));
  end

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           samp_end,
  input  logic [RES-1:0] dec,
  input  logic           cmp_above,
  output logic [RES-1:0] trial
);
  logic [RES-1:0] nxt;

  always_comb begin
    nxt = trial;
    for (int i = 0; i < RES; i++) begin
      if (dec[i]) nxt[i] = cmp_above;
    end
    for (int i = 0; i < RES - 1; i++) begin
      if (dec[i+1]) nxt[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         trial <= '0;
    else if (load)      trial <= '0;
    else if (samp_end)  trial <= {1'b1, {(RES-1){1'b0}}};
    else                trial <= nxt;
  end

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int RES       = 8,
  parameter int NCH       = 8,
  parameter int SAMP_CLKS = 12,
  parameter int BIT_CLKS  = 17,
  parameter int CONV_CLKS = 160,
  parameter int MAX_DIV   = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [$clog2(NCH)-1:0] chan_sel,
  input  logic [1:0]             psc_code,
  input  logic                   clk_half,
  input  logic                   irq_clr,
  input  logic                   cmp_above,
  output logic [$clog2(NCH)-1:0] mux_sel,
  output logic                   sample_hold,
  output logic [RES-1:0]         trial_code,
  output logic                   busy,
  output logic [RES-1:0]         result,
  output logic                   done_pulse,
  output logic                   irq_flag
);
  localparam int CHW = $clog2(NCH);

  logic           load;
  logic           tick;
  logic           samp_end;
  logic           conv_end;
  logic [RES-1:0] dec;
  logic [CHW-1:0] chan_q;

  assign load = start && !busy;

  sar_clk_div #(.MAX_DIV(MAX_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load),
    .run  (busy),
    .psc  (psc_code),
    .half (clk_half),
    .tick (tick)
  );

  sar_phase_ctr #(
    .RES  (RES),
    .SAMP (SAMP_CLKS),
    .BITP (BIT_CLKS),
    .TOTAL(CONV_CLKS)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .run     (busy),
    .tick    (tick),
    .sampling(sample_hold),
    .samp_end(samp_end),
    .dec     (dec),
    .conv_end(conv_end)
  );

  sar_approx_reg #(.RES(RES)) u_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .samp_end (samp_end),
    .dec      (dec),
    .cmp_above(cmp_above),
    .trial    (trial_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      chan_q     <= '0;
      result     <= '0;
      done_pulse <= 1'b0;
      irq_flag   <= 1'b0;
    end else begin
      done_pulse <= conv_end;
      if (load) begin
        busy   <= 1'b1;
        chan_q <= chan_sel;
      end else if (conv_end) begin
        busy   <= 1'b0;
      end
      if (conv_end) result <= trial_code;
      if (conv_end)      irq_flag <= 1'b1;   // completion wins over a clear
      else if (irq_clr)  irq_flag <= 1'b0;
    end
  end

  assign mux_sel = chan_q;

endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int RES = 8,
  parameter int NCH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   irq_clr,
  input logic                   sample_hold,
  input logic                   busy,
  input logic                   done_pulse,
  input logic                   irq_flag,
  input logic [$clog2(NCH)-1:0] mux_sel,
  input logic [RES-1:0]         trial_code
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !irq_flag && !done_pulse && !sample_hold));

  assert_mux_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mux_sel));

  assert_sample_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hold |-> (busy && trial_code == '0));

  assert_msb_trial_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sample_hold) && busy) |-> (trial_code == {1'b1, {(RES-1){1'b0}}}));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  assert_done_sets_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> irq_flag);

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  assert_busy_ends_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_pulse);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !busy);

endmodule

bind sar_adc_seq sar_adc_seq_chk #(.RES(RES), .NCH(NCH)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_clr    (irq_clr),
  .sample_hold(sample_hold),
  .busy       (busy),
  .done_pulse (done_pulse),
  .irq_flag   (irq_flag),
  .mux_sel    (mux_sel),
  .trial_code (trial_code)
);

// File: tb/test_sar_adc_seq.sv
module test_sar_adc_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] chan_sel = '0;
  logic [1:0] psc_code = '0;
  logic       clk_half = 1'b0;
  logic       irq_clr = 1'b0;
  logic       cmp_above;
  logic [2:0] mux_sel;
  logic       sample_hold;
  logic [7:0] trial_code;
  logic       busy;
  logic [7:0] result;
  logic       done_pulse;
  logic       irq_flag;

  logic [7:0] ain [8];

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  // ideal comparator on the selected channel
  assign cmp_above = (ain[mux_sel] >= trial_code);

  sar_adc_seq i_sar_adc_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .psc_code(psc_code), .clk_half(clk_half), .irq_clr(irq_clr),
    .cmp_above(cmp_above), .mux_sel(mux_sel), .sample_hold(sample_hold),
    .trial_code(trial_code), .busy(busy), .result(result),
    .done_pulse(done_pulse), .irq_flag(irq_flag)
  );

  // {psc[1:0], half, chan[2:0], level[7:0]}
  localparam logic [13:0] VEC [8] = '{
    {2'b00, 1'b0, 3'd0, 8'h00},
    {2'b00, 1'b0, 3'd7, 8'hFF},
    {2'b01, 1'b0, 3'd3, 8'h80},
    {2'b01, 1'b1, 3'd4, 8'h7F},
    {2'b11, 1'b0, 3'd1, 8'h55},
    {2'b10, 1'b0, 3'd6, 8'hAA},
    {2'b00, 1'b1, 3'd2, 8'h01},
    {2'b11, 1'b1, 3'd5, 8'hC3}
  };

  function automatic int exp_div(input logic [1:0] p, input logic h);
    int b;
    b = (p == 2'b00) ? 2 : (p == 2'b01) ? 4 : 16;
    return h ? 2 * b : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic set_levels(input logic [2:0] ch, input logic [7:0] lvl);
    for (int c = 0; c < 8; c++) ain[c] = ~lvl;
    ain[ch] = lvl;
  endtask

  // Pulse start on a falling edge; returns after the accepting rising edge.
  task automatic kick(input logic [1:0] p, input logic h, input logic [2:0] ch);
    @(negedge clk);
    psc_code = p; clk_half = h; chan_sel = ch; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(inout int lat, output bit gap, output bit mux_bad,
                           input logic [2:0] ch);
    gap = 1'b0; mux_bad = 1'b0;
    while (!done_pulse && lat < 6000) begin
      if (!busy) gap = 1'b1;
      if (mux_sel != ch) mux_bad = 1'b1;
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic run_all();
    int lat; bit gap; bit mbad; int n; int c;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done_pulse && !irq_flag && !sample_hold, "R1 status in reset",
        {busy, done_pulse, irq_flag, sample_hold}, 0);
    chk(result == 8'h00 && trial_code == 8'h00, "R1 codes in reset", {result, trial_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !irq_flag && result == 8'h00, "R1 idle after release", {busy, irq_flag, result}, 0);

    // vector table: R2 R5 R6 R7 R9 R10
    foreach (VEC[i]) begin
      logic [1:0] p; logic h; logic [2:0] ch; logic [7:0] lvl;
      {p, h, ch, lvl} = VEC[i];
      n = exp_div(p, h);
      set_levels(ch, lvl);
      kick(p, h, ch);
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      chan_sel = ~ch;  // must not disturb the latched select
      lat = 0;
      wait_done(lat, gap, mbad, ch);
      chk(lat == 160 * n, "R6/R7 done latency", lat, 160 * n);
      chk(result == lvl, "R5 result code", result, lvl);
      chk(!gap && !busy, "R10 busy continuous then low at done", {gap, busy}, 0);
      chk(!mbad, "R2 mux_sel held", mux_sel, ch);
      chk(irq_flag, "R9 irq set at done", irq_flag, 1);
      @(negedge clk);
      chk(!done_pulse, "R9 done one cycle", done_pulse, 0);
      repeat (5) @(negedge clk);
      chk(irq_flag, "R9 irq sticky", irq_flag, 1);
      clear_irq();
      chk(!irq_flag, "R9 irq cleared", irq_flag, 0);
    end

    // R3 sampling window and R4 bit order, N = 2
    set_levels(3'd1, 8'h40);
    kick(2'b00, 1'b0, 3'd1);
    c = 0;
    while (sample_hold && c < 1000) begin
      if (trial_code != 8'h00) chk(0, "R3 trial zero while sampling", trial_code, 0);
      @(negedge clk); c++;
    end
    chk(c == 24, "R3 sampling length", c, 24);
    chk(trial_code == 8'h80, "R4 MSB trial after sampling", trial_code, 8'h80);
    repeat (34) @(negedge clk);
    chk(trial_code == 8'h40, "R4 MSB cleared and next bit set", trial_code, 8'h40);
    repeat (34) @(negedge clk);
    chk(trial_code == 8'h60, "R4 second bit kept and third set", trial_code, 8'h60);
    lat = 0;
    wait_done(lat, gap, mbad, 3'd1);
    chk(result == 8'h40, "R5 result after step check", result, 8'h40);
    clear_irq();

    // R8 start while busy is ignored
    set_levels(3'd2, 8'h3C);
    ain[5] = 8'hE1;
    kick(2'b01, 1'b0, 3'd2);
    lat = 0;
    repeat (100) begin @(negedge clk); lat++; end
    chan_sel = 3'd5; psc_code = 2'b11; clk_half = 1'b1; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    wait_done(lat, gap, mbad, 3'd2);
    chk(lat == 640, "R8 timing unchanged by second start", lat, 640);
    chk(result == 8'h3C, "R8 result unchanged by second start", result, 8'h3C);
    chk(mux_sel == 3'd2 && !mbad, "R8 channel unchanged", mux_sel, 2);
    clear_irq();

    // R9 completion wins over a simultaneous clear
    set_levels(3'd0, 8'h9A);
    kick(2'b00, 1'b0, 3'd0);
    irq_clr = 1'b1;
    lat = 0;
    wait_done(lat, gap, mbad, 3'd0);
    chk(irq_flag == 1'b1, "R9 set wins over clear", irq_flag, 1);
    irq_clr = 1'b0;
    chk(result == 8'h9A, "R5 result with clear held", result, 8'h9A);
  endtask

  initial begin
    for (int c = 0; c < 8; c++) ain[c] = 8'h00;
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R6 watchdog: actual hung expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule